// File: doc/BRIEF.md
# Branch discontinuity trace buffer

This block sits beside a processor's retire stage and keeps a short history of taken control-flow changes. Each time a retired taken branch is signalled, its source and target addresses are stored as one entry. Capture needs two separate control bits to be on: a power bit and an enable bit. With power on and enable off, capture stops but the stored entries stay readable.

Software uses a small register port with three registers: control, status and a data window. Entries come out of the data window newest first. Each entry takes two reads: the target address first, then the source address. The status register gives the number of complete entries held. That count drops only when the second half of an entry has been read.

When the history is full, a new capture overwrites the oldest entry and sets a sticky overflow flag. Turning power off empties the history.

Top module: `flow_trace_buf`

## Requirements
- R1: Register select 0 is control, 1 is status and 2 is data. Select 3 reads as 0. Read data appears on `reg_rdata_o` in the cycle after `reg_rd_i` is high, and holds until the next read.
- R1 (continued): Control layout is bit 0 power, bit 1 enable, bit 2 overflow and bits 4:3 a stored mode field that reads back as written. After reset, control reads 0.
- R2: A retire strobe is recorded as an entry only while power and enable are both 1.
- R3: A retire strobe with only one of power or enable set creates no entry.
- R4: Status bits 4:0 hold the count of complete entries (0 to DEPTH). The count is 0 after reset and 1 after one recorded branch.
- R5: Entries are read newest first. The first data read of an entry returns its target address. The second data read returns its source address.
- R6: The status count stays the same after the first read of an entry. It decrements by one after the second read.
- R7: Writing control with power=1 and enable=0 stops capture. Entries already held stay readable.
- R8: A capture while DEPTH entries are held discards the oldest entry and sets the overflow bit. The count stays at DEPTH. The overflow bit stays set until control is written with bit 2 equal to 0. Writing bit 2 as 1 has no effect.
- R9: A control write with power=0 empties the history and clears the count. It also resets the read-half toggle, so the next entry read starts with its target.
- R10: A data read while the history is empty returns 0 and changes neither the count nor the toggle.
- R11: A capture while an entry is half-read resets the toggle. The next data read returns the new entry's target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| retire_vld_i | input | 1 | A taken branch retires this cycle |
| retire_src_i | input | AW | Address of the branch |
| retire_dst_i | input | AW | Branch target address |
| reg_sel_i | input | 2 | Register select |
| reg_wr_i | input | 1 | Write strobe (control only) |
| reg_rd_i | input | 1 | Read strobe |
| reg_wdata_i | input | DW | Write data |
| reg_rdata_o | output | DW | Registered read data |

## Verification
The bench drives 17 captures into a 16-entry history and checks that the oldest entry is lost. A design that dropped the newest entry instead, or let the count pass 16, would return the wrong pairs or a wrong status. The bench checks that the count does not change between the two halves of a read. A design that decremented early would show it as soon as the first half is read. It turns power off in the middle of a pair. A design that kept the half toggle would then return a source where a target is due. It also captures a new branch between the two halves of a read. This exposes a design that mixes the new target with an old source, or that changes state on a read of an empty history.

// File: rtl/ft_pkg.sv
package ft_pkg;
  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_STAT = 2'd1,
    SEL_DATA = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  // bit order is the software-visible control layout
  typedef struct packed {
    logic [1:0] mode;
    logic       ovf;
    logic       en;
    logic       pwr;
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/ft_ctrl.sv
module ft_ctrl
  import ft_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  wr_i,
  input  ctrl_t wdata_i,
  input  logic  drop_i,
  output ctrl_t ctrl_o,
  output logic  flush_o
);
  ctrl_t ctrl_q;

  assign flush_o = wr_i & ~wdata_i.pwr;
  assign ctrl_o  = ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else begin
      if (wr_i) begin
        ctrl_q.pwr  <= wdata_i.pwr;
        ctrl_q.en   <= wdata_i.en;
        ctrl_q.mode <= wdata_i.mode;
      end
      // sticky: a loss event wins over a same-cycle clear
      if (drop_i)                 ctrl_q.ovf <= 1'b1;
      else if (wr_i && !wdata_i.ovf) ctrl_q.ovf <= 1'b0;
    end
  end
endmodule

// File: rtl/ft_lifo.sv
module ft_lifo #(
  parameter int unsigned AW    = 32,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned PW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic [AW-1:0] push_src_i,
  input  logic [AW-1:0] push_dst_i,
  input  logic          rd_i,
  output logic [AW-1:0] word_o,
  output logic [CW-1:0] cnt_o,
  output logic          half_o,
  output logic          drop_o
);
  logic [AW-1:0] src_mem [DEPTH];
  logic [AW-1:0] dst_mem [DEPTH];
  logic [PW-1:0] wp_q;
  logic [CW-1:0] cnt_q;
  logic          half_q;

  logic          empty, full, rd_act, pop;
  logic [PW-1:0] top_idx, wr_idx;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign rd_act  = rd_i & ~empty;
  assign pop     = rd_act & half_q;
  assign top_idx = wp_q - PW'(1);
  // pop and push together reuse the popped slot
  assign wr_idx  = pop ? top_idx : wp_q;
  assign drop_o  = push_i & ~pop & full & ~flush_i;

  assign word_o  = empty ? '0 : (half_q ? src_mem[top_idx] : dst_mem[top_idx]);
  assign cnt_o   = cnt_q;
  assign half_o  = half_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q   <= '0;
      cnt_q  <= '0;
      half_q <= 1'b0;
    end else if (flush_i) begin
      wp_q   <= '0;
      cnt_q  <= '0;
      half_q <= 1'b0;
    end else begin
      if (push_i && !pop)      wp_q <= wp_q + PW'(1);
      else if (pop && !push_i) wp_q <= wp_q - PW'(1);

      if (push_i && !pop && !full) cnt_q <= cnt_q + CW'(1);
      else if (pop && !push_i)     cnt_q <= cnt_q - CW'(1);

      if (push_i)      half_q <= 1'b0;
      else if (rd_act) half_q <= ~half_q;
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i && !flush_i) begin
      src_mem[wr_idx] <= push_src_i;
      dst_mem[wr_idx] <= push_dst_i;
    end
  end
endmodule

// File: rtl/ft_rdmux.sv
module ft_rdmux
  import ft_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32,
  parameter int unsigned CW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_i,
  input  reg_sel_e      sel_i,
  input  ctrl_t         ctrl_i,
  input  logic [CW-1:0] cnt_i,
  input  logic [AW-1:0] word_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] rdata_q, rdata_d;

  always_comb begin
    unique case (sel_i)
      SEL_CTRL: rdata_d = DW'(ctrl_i);
      SEL_STAT: rdata_d = DW'(cnt_i);
      SEL_DATA: rdata_d = DW'(word_i);
      default:  rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (rd_i) rdata_q <= rdata_d;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/flow_trace_buf.sv
module flow_trace_buf
  import ft_pkg::*;
#(
  parameter int unsigned AW    = 32,
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          retire_vld_i,
  input  logic [AW-1:0] retire_src_i,
  input  logic [AW-1:0] retire_dst_i,
  input  logic [1:0]    reg_sel_i,
  input  logic          reg_wr_i,
  input  logic          reg_rd_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o
);
  reg_sel_e      sel;
  ctrl_t         ctrl;
  logic          ctrl_wr, data_rd, capture, flush, drop, half;
  logic [CW-1:0] cnt;
  logic [AW-1:0] word;

  assign sel     = reg_sel_e'(reg_sel_i);
  assign ctrl_wr = reg_wr_i & (sel == SEL_CTRL);
  assign data_rd = reg_rd_i & (sel == SEL_DATA);
  assign capture = retire_vld_i & ctrl.pwr & ctrl.en;

  ft_ctrl u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (ctrl_wr),
    .wdata_i (ctrl_t'(reg_wdata_i[CTRL_W-1:0])),
    .drop_i  (drop),
    .ctrl_o  (ctrl),
    .flush_o (flush)
  );

  ft_lifo #(.AW(AW), .DEPTH(DEPTH)) u_lifo (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .flush_i    (flush),
    .push_i     (capture),
    .push_src_i (retire_src_i),
    .push_dst_i (retire_dst_i),
    .rd_i       (data_rd),
    .word_o     (word),
    .cnt_o      (cnt),
    .half_o     (half),
    .drop_o     (drop)
  );

  ft_rdmux #(.AW(AW), .DW(DW), .CW(CW)) u_rdmux (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rd_i    (reg_rd_i),
    .sel_i   (sel),
    .ctrl_i  (ctrl),
    .cnt_i   (cnt),
    .word_i  (word),
    .rdata_o (reg_rdata_o)
  );
endmodule

// File: rtl/ft_checker.sv
module ft_checker
  import ft_pkg::*;
#(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 16,
  parameter int unsigned CW    = 5
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          retire_vld_i,
  input logic [1:0]    reg_sel_i,
  input logic          reg_wr_i,
  input logic          reg_rd_i,
  input logic [DW-1:0] reg_wdata_i,
  input logic [DW-1:0] reg_rdata_o,
  input ctrl_t         ctrl,
  input logic [CW-1:0] cnt,
  input logic          half
);
  logic cap, cwr, drd;
  assign cap = retire_vld_i & ctrl.pwr & ctrl.en;
  assign cwr = reg_wr_i & (reg_sel_i == 2'd0);
  assign drd = reg_rd_i & (reg_sel_i == 2'd2);

  a_r3_no_capture_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retire_vld_i && !(ctrl.pwr && ctrl.en) && !drd && !cwr |=> $stable(cnt));

  a_r4_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt <= CW'(DEPTH));

  a_r6_first_read_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drd && cnt != '0 && !half && !cap && !cwr |=> $stable(cnt) && half);

  a_r6_second_read_dec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drd && cnt != '0 && half && !cap && !cwr |=> cnt == $past(cnt) - CW'(1) && !half);

  a_r8_overflow_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap && cnt == CW'(DEPTH) && !drd && !cwr |=> ctrl.ovf && cnt == CW'(DEPTH));

  a_r9_power_off_flush: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cwr && !reg_wdata_i[0] |=> cnt == '0 && !half);

  a_r10_empty_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drd && cnt == '0 && !cap && !cwr |=> reg_rdata_o == '0 && cnt == '0 && !half);

  a_r11_capture_restarts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap && !cwr |=> !half);
endmodule

bind flow_trace_buf ft_checker #(.DW(DW), .DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .retire_vld_i (retire_vld_i),
  .reg_sel_i    (reg_sel_i),
  .reg_wr_i     (reg_wr_i),
  .reg_rd_i     (reg_rd_i),
  .reg_wdata_i  (reg_wdata_i),
  .reg_rdata_o  (reg_rdata_o),
  .ctrl         (ctrl),
  .cnt          (cnt),
  .half         (half)
);

// File: tb/sim_flow_trace_buf.sv
module sim_flow_trace_buf;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int DEPTH = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          vld = 1'b0;
  logic [AW-1:0] src = '0, dst = '0;
  logic [1:0]    sel = 2'd0;
  logic          wr = 1'b0, rd = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  flow_trace_buf #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .retire_vld_i(vld), .retire_src_i(src),
    .retire_dst_i(dst), .reg_sel_i(sel), .reg_wr_i(wr), .reg_rd_i(rd),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: act 0x%0h exp 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr_ctrl(input logic [DW-1:0] d);
    @(negedge clk); sel = 2'd0; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] s, output logic [DW-1:0] d);
    @(negedge clk); sel = s; rd = 1'b1;
    @(negedge clk); rd = 1'b0; d = rdata;
  endtask

  task automatic retire(input logic [AW-1:0] s, input logic [AW-1:0] t);
    @(negedge clk); src = s; dst = t; vld = 1'b1;
    @(negedge clk); vld = 1'b0;
  endtask

  task automatic t_reset;
    logic [DW-1:0] d;
    rd_reg(2'd0, d); chk("R1 ctrl reset", d, 0);
    rd_reg(2'd1, d); chk("R4 status reset", d, 0);
    rd_reg(2'd2, d); chk("R10 empty data", d, 0);
    rd_reg(2'd1, d); chk("R10 count kept", d, 0);
    rd_reg(2'd3, d); chk("R1 unused select", d, 0);
    wr_ctrl(32'h19);
    rd_reg(2'd0, d); chk("R1 mode readback", d, 32'h19);
    wr_ctrl(32'h0);
  endtask

  task automatic t_gating;
    logic [DW-1:0] d;
    wr_ctrl(32'h2); retire(32'h10, 32'h20);
    rd_reg(2'd1, d); chk("R3 enable only", d, 0);
    wr_ctrl(32'h1); retire(32'h10, 32'h20);
    rd_reg(2'd1, d); chk("R3 power only", d, 0);
    wr_ctrl(32'h3); retire(32'hA0, 32'hB0);
    rd_reg(2'd1, d); chk("R2 R4 one entry", d, 1);
  endtask

  task automatic t_pop_order;
    logic [DW-1:0] d;
    retire(32'hC0, 32'hD0);
    rd_reg(2'd1, d); chk("R4 two entries", d, 2);
    rd_reg(2'd2, d); chk("R5 newest target", d, 32'hD0);
    rd_reg(2'd1, d); chk("R6 count after first", d, 2);
    rd_reg(2'd2, d); chk("R5 newest source", d, 32'hC0);
    rd_reg(2'd1, d); chk("R6 count after second", d, 1);
    rd_reg(2'd2, d); chk("R5 older target", d, 32'hB0);
    rd_reg(2'd2, d); chk("R5 older source", d, 32'hA0);
    rd_reg(2'd1, d); chk("R6 drained", d, 0);
    rd_reg(2'd2, d); chk("R10 empty after drain", d, 0);
  endtask

  task automatic t_stop_keep;
    logic [DW-1:0] d;
    wr_ctrl(32'h3); retire(32'h100, 32'h200);
    wr_ctrl(32'h1); retire(32'h300, 32'h400);
    rd_reg(2'd1, d); chk("R7 capture stopped", d, 1);
    rd_reg(2'd2, d); chk("R7 held target", d, 32'h200);
    rd_reg(2'd2, d); chk("R7 held source", d, 32'h100);
  endtask

  task automatic t_overflow;
    logic [DW-1:0] d;
    wr_ctrl(32'h3);
    for (int i = 0; i <= DEPTH; i++) retire(32'h1000 + i, 32'h2000 + i);
    rd_reg(2'd1, d); chk("R8 count saturates", d, DEPTH);
    rd_reg(2'd0, d); chk("R8 overflow set", d, 32'h7);
    wr_ctrl(32'h7);
    rd_reg(2'd0, d); chk("R8 write one keeps", d, 32'h7);
    for (int i = DEPTH; i >= 1; i--) begin
      rd_reg(2'd2, d); chk("R8 pop target", d, 32'h2000 + i);
      rd_reg(2'd2, d); chk("R8 pop source", d, 32'h1000 + i);
    end
    rd_reg(2'd1, d); chk("R8 oldest discarded", d, 0);
    wr_ctrl(32'h3);
    rd_reg(2'd0, d); chk("R8 overflow cleared", d, 32'h3);
  endtask

  task automatic t_flush;
    logic [DW-1:0] d;
    retire(32'h11, 32'h22); retire(32'h33, 32'h44);
    rd_reg(2'd2, d); chk("R5 half read", d, 32'h44);
    wr_ctrl(32'h0);
    rd_reg(2'd1, d); chk("R9 emptied", d, 0);
    wr_ctrl(32'h3); retire(32'h55, 32'h66);
    rd_reg(2'd2, d); chk("R9 toggle reset", d, 32'h66);
    rd_reg(2'd2, d); chk("R9 source next", d, 32'h55);
  endtask

  task automatic t_restart;
    logic [DW-1:0] d;
    retire(32'hE0, 32'hF0);
    rd_reg(2'd2, d); chk("R5 first target", d, 32'hF0);
    retire(32'hE8, 32'hF8);
    rd_reg(2'd2, d); chk("R11 new target", d, 32'hF8);
    rd_reg(2'd2, d); chk("R11 new source", d, 32'hE8);
    rd_reg(2'd2, d); chk("R11 old target", d, 32'hF0);
    rd_reg(2'd2, d); chk("R11 old source", d, 32'hE0);
    rd_reg(2'd1, d); chk("R11 drained", d, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_gating();
    t_pop_order();
    t_stop_keep();
    t_overflow();
    t_flush();
    t_restart();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: act hung exp done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule